// File: doc/BRIEF.md
# Vertex Command Stream Parser

This block sits at the front of a vertex command engine. It takes a stream of 32-bit command words over a valid/ready handshake and divides it into typed command blocks. The type of each block comes from the top three bits of its first word. The header's presence flags decide how many optional payload words follow. Each block is padded out to a whole number of 8-byte units, and the parser discards that padding.

For every block the parser presents one decoded record on a second valid/ready handshake. The record carries the raw type, an unknown-type flag, the decoded header fields, a presence mask with one bit per payload slot, and the captured payload values. The parser does not accept input words while a record is waiting downstream. A terminate block ends parsing, and the parser then stays idle until it is reset. The parser does not fetch memory at the decoded pointers and does not execute draws.

Top module: `vcp_cmd_parser`

## Requirements
- R1: The block type is taken from header bits 31:29. The recognised codes are 0 (state pointer), 2 (vertex state), 3 (index list) and 6 (terminate). Every other code is reported with `rec_unknown` high. `rec_type` always shows the raw 3-bit code.
- R2: A state-pointer block is four words long.
  - The header holds address bits 39:32 in bits 7:0. The parser reports them on `rec_addr_hi`.
  - Word 2 is the low 32 address bits and goes to field slot 0.
  - Word 3 carries the size in its bits 23:0. Slot 1 holds that size zero-extended, and the upper 8 bits of the word are dropped.
  - Word 4 is padding.
  - The presence mask reads 00011.
- R3: A vertex-state header carries its presence flags in bits 4:0. Bit 0 is restart index, bit 1 is shader word 0, bit 2 is shader word 1, bit 3 is outputs and bit 4 is an auxiliary word. Only the flagged words follow, in that bit order. Each flagged word is stored in the slot whose number equals its flag bit. All other header bits are ignored.
- R4: An index-list header carries the following fields. The payload words follow in the same flag order, one per set bit.
  - Bits 4:0: presence flags. Bit 0 is buffer low address, bit 1 is count, bit 2 is instances, bit 3 is start and bit 4 is buffer size.
  - Bits 6:5: index-size code.
  - Bit 7: restart enable.
  - Bits 11:8: primitive.
  - Bits 19:12: buffer address bits 39:32.
- R5: For an index list, `rec_idx_bytes` reports the index size as 1, 2 or 4 for codes 0, 1 and 2, and 0 for code 3. For all other block types the primitive, restart enable, size code and size bytes read zero.
- R6: A vertex-state or index-list block whose header plus payload count is odd is followed by exactly one pad word. The parser consumes and discards that pad word.
- R7: An unknown-type header is consumed together with exactly one following word. Its record has an empty presence mask.
- R8: A terminate block is a single word. Its record is emitted, and after it is accepted `done` stays high and `in_ready` stays low until reset.
- R9: A record appears only after the block's last word, padding included, has been consumed. Exactly one record is produced per block, in stream order.
- R10: `in_ready` is low while a record is pending. A pending record holds steady until it is accepted. No word is lost or duplicated under back-pressure on either side.
- R11: A synchronous active-high reset returns the parser to waiting for a header. After reset, `done` and `rec_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Parser takes the word this cycle |
| in_data | input | 32 | Command word |
| rec_valid | output | 1 | Decoded record pending |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_type | output | 3 | Raw block type code |
| rec_unknown | output | 1 | Type code not recognised |
| rec_present | output | 5 | Payload slot valid bits |
| rec_fields | output | 160 | Payload slots, slot n at bits 32n+31:32n |
| rec_prim | output | 4 | Primitive (index list) |
| rec_restart_en | output | 1 | Restart enable (index list) |
| rec_idx_log | output | 2 | Index-size code (index list) |
| rec_idx_bytes | output | 3 | Index size in bytes (index list) |
| rec_addr_hi | output | 8 | Address bits 39:32 (pointer or index list) |
| done | output | 1 | Terminate seen; parser idle |

## Verification
If the parser miscounts a block's length, it loses alignment with the stream. The next record then appears at the wrong consumed-word count and usually decodes a payload or pad word as a header, so the bench sees the error on the very next record. The bench records how many input words have been consumed each time a record is accepted, which exposes a premature record or a skipped pad word at once. A bad slot choice shows as a field value in the wrong slot within the same record. A broken stall shows as a moved word count or a changed record during back-pressure cycles.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] T_PTR = 3'd0;
  localparam logic [TYPE_W-1:0] T_VTX = 3'd2;
  localparam logic [TYPE_W-1:0] T_IDX = 3'd3;
  localparam logic [TYPE_W-1:0] T_END = 3'd6;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_OUT,
    ST_DONE
  } parse_st_e;
endpackage

// File: rtl/vcp_hdr_dec.sv
module vcp_hdr_dec
  import vcp_pkg::*;
#(
  parameter int NF = 5
) (
  input  logic [TYPE_W-1:0] btype,
  input  logic [NF-1:0]     flags,
  output logic              known,
  output logic              is_end,
  output logic [NF-1:0]     mask,
  output logic              pad
);
  always_comb begin
    known  = 1'b1;
    is_end = 1'b0;
    mask   = '0;
    pad    = 1'b0;
    unique case (btype)
      T_PTR: begin
        mask = NF'(2'b11);
        pad  = 1'b1;
      end
      T_VTX, T_IDX: begin
        mask = flags;
        pad  = ($countones(flags) % 2) == 0;
      end
      T_END: is_end = 1'b1;
      default: begin
        known = 1'b0;
        pad   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vcp_slot_pick.sv
module vcp_slot_pick #(
  parameter int NF = 5,
  localparam int SW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF-1:0] rem,
  output logic [SW-1:0] idx,
  output logic [NF-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NF - 1; i >= 0; i--) begin
      if (rem[i]) idx = SW'(i);
    end
    onehot = NF'(1) << idx;
  end
endmodule

// File: rtl/vcp_cmd_parser.sv
module vcp_cmd_parser
  import vcp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NF     = 5,
  parameter int PRIM_W = 4,
  parameter int AHI_W  = 8,
  parameter int SIZE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [TYPE_W-1:0] rec_type,
  output logic              rec_unknown,
  output logic [NF-1:0]     rec_present,
  output logic [NF*DW-1:0]  rec_fields,
  output logic [PRIM_W-1:0] rec_prim,
  output logic              rec_restart_en,
  output logic [1:0]        rec_idx_log,
  output logic [2:0]        rec_idx_bytes,
  output logic [AHI_W-1:0]  rec_addr_hi,
  output logic              done
);
  localparam int SW       = (NF > 1) ? $clog2(NF) : 1;
  localparam int LOG_LSB  = NF;
  localparam int RST_BIT  = NF + 2;
  localparam int PRIM_LSB = NF + 3;
  localparam int AHI_LSB  = PRIM_LSB + PRIM_W;

  parse_st_e       state;
  logic [NF-1:0]   rem;
  logic            pad_q;
  logic            term_q;
  logic [DW-1:0]   fld [NF];

  logic            d_known, d_end, d_pad;
  logic [NF-1:0]   d_mask;
  logic [SW-1:0]   pk_idx;
  logic [NF-1:0]   pk_oh;
  logic [NF-1:0]   rem_nxt;
  logic            fire;

  vcp_hdr_dec #(.NF(NF)) u_dec (
    .btype (in_data[DW-1 -: TYPE_W]),
    .flags (in_data[NF-1:0]),
    .known (d_known),
    .is_end(d_end),
    .mask  (d_mask),
    .pad   (d_pad)
  );

  vcp_slot_pick #(.NF(NF)) u_pick (
    .rem   (rem),
    .idx   (pk_idx),
    .onehot(pk_oh)
  );

  assign in_ready  = (state == ST_HDR) || (state == ST_PAY) || (state == ST_PAD);
  assign rec_valid = (state == ST_OUT);
  assign done      = (state == ST_DONE);
  assign fire      = in_valid && in_ready;
  assign rem_nxt   = rem & ~pk_oh;

  for (genvar g = 0; g < NF; g++) begin : g_pack
    assign rec_fields[g*DW +: DW] = fld[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HDR;
      rem   <= '0;
      pad_q <= 1'b0;
      term_q <= 1'b0;
    end else begin
      unique case (state)
        ST_HDR: if (fire) begin
          rec_type       <= in_data[DW-1 -: TYPE_W];
          rec_unknown    <= !d_known;
          rec_present    <= '0;
          rec_prim       <= '0;
          rec_restart_en <= 1'b0;
          rec_idx_log    <= '0;
          rec_idx_bytes  <= '0;
          rec_addr_hi    <= '0;
          for (int i = 0; i < NF; i++) fld[i] <= '0;
          if (in_data[DW-1 -: TYPE_W] == T_IDX) begin
            rec_prim       <= in_data[PRIM_LSB +: PRIM_W];
            rec_restart_en <= in_data[RST_BIT];
            rec_idx_log    <= in_data[LOG_LSB +: 2];
            rec_addr_hi    <= in_data[AHI_LSB +: AHI_W];
            case (in_data[LOG_LSB +: 2])
              2'd0:    rec_idx_bytes <= 3'd1;
              2'd1:    rec_idx_bytes <= 3'd2;
              2'd2:    rec_idx_bytes <= 3'd4;
              default: rec_idx_bytes <= 3'd0;
            endcase
          end else if (in_data[DW-1 -: TYPE_W] == T_PTR) begin
            rec_addr_hi <= in_data[AHI_W-1:0];
          end
          rem    <= d_mask;
          pad_q  <= d_pad;
          term_q <= d_end;
          if (d_end)            state <= ST_OUT;
          else if (d_mask != '0) state <= ST_PAY;
          else if (d_pad)       state <= ST_PAD;
          else                  state <= ST_OUT;
        end
        ST_PAY: if (fire) begin
          if (rec_type == T_PTR && pk_idx == SW'(1))
            fld[pk_idx] <= DW'(in_data[SIZE_W-1:0]);
          else
            fld[pk_idx] <= in_data;
          rec_present <= rec_present | pk_oh;
          rem <= rem_nxt;
          if (rem_nxt == '0) state <= pad_q ? ST_PAD : ST_OUT;
        end
        ST_PAD: if (fire) state <= ST_OUT;
        ST_OUT: if (rec_ready) state <= term_q ? ST_DONE : ST_HDR;
        ST_DONE: state <= ST_DONE;
        default: state <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/vcp_cmd_parser_chk.sv
module vcp_cmd_parser_chk #(
  parameter int DW = 32,
  parameter int NF = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [2:0]       rec_type,
  input logic             rec_unknown,
  input logic [NF-1:0]    rec_present,
  input logic [NF*DW-1:0] rec_fields,
  input logic [1:0]       rec_idx_log,
  input logic [2:0]       rec_idx_bytes,
  input logic             done
);
  // R10: input stalls while a record waits
  a_r10_stall_in: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !in_ready);

  // R10: a pending record holds until taken
  a_r10_hold_rec: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_fields)
      && $stable(rec_present) && $stable(rec_type));

  // R8: accepted terminate leads to done
  a_r8_term_done: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_ready && !rec_unknown && rec_type == 3'd6 |=> done);

  // R8: done is sticky and silent
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !in_ready && !rec_valid);

  // R7: unknown blocks carry no payload
  a_r7_unknown_empty: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_unknown |-> rec_present == '0);

  // R2: pointer block fills exactly slots 0 and 1
  a_r2_ptr_slots: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_unknown && rec_type == 3'd0 |-> rec_present == NF'(2'b11));

  // R5: legal size codes give a single power of two
  a_r5_size_pow2: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_type == 3'd3 && rec_idx_log != 2'd3 |-> $countones(rec_idx_bytes) == 1);

  // R11: first cycle after reset is idle
  a_r11_after_rst: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rec_valid && !done && in_ready);
endmodule

bind vcp_cmd_parser vcp_cmd_parser_chk #(.DW(DW), .NF(NF)) u_chk (.*);

// File: tb/tb_vcp_cmd_parser.sv
module tb_vcp_cmd_parser;
  localparam int RW = 187;
  localparam int MAXW = 2048;
  localparam int MAXE = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic rec_valid;
  logic rec_ready = 1'b0;
  logic [2:0] rec_type;
  logic rec_unknown;
  logic [4:0] rec_present;
  logic [159:0] rec_fields;
  logic [3:0] rec_prim;
  logic rec_restart_en;
  logic [1:0] rec_idx_log;
  logic [2:0] rec_idx_bytes;
  logic [7:0] rec_addr_hi;
  logic done;

  always #2.5 clk = ~clk;

  vcp_cmd_parser dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_type(rec_type),
    .rec_unknown(rec_unknown), .rec_present(rec_present), .rec_fields(rec_fields),
    .rec_prim(rec_prim), .rec_restart_en(rec_restart_en), .rec_idx_log(rec_idx_log),
    .rec_idx_bytes(rec_idx_bytes), .rec_addr_hi(rec_addr_hi), .done(done)
  );

  logic [31:0] wq [MAXW];
  logic [RW-1:0] e_rec [MAXE];
  int e_end [MAXE];
  string e_tag [MAXE];
  int nw = 0, ne = 0;
  int acc = 0, got = 0, cyc = 0;
  int n_chk = 0, n_bad = 0;
  logic run = 1'b0, bp = 1'b0;

  function automatic logic [RW-1:0] mk(input logic [2:0] t, input logic unk, input logic [4:0] pr,
      input logic [159:0] f, input logic [3:0] pm, input logic re, input logic [1:0] lg,
      input logic [7:0] ah);
    logic [2:0] by;
    by = (t == 3'd3 && !unk) ? ((lg == 2'd3) ? 3'd0 : 3'(1 << lg)) : 3'd0;
    return {t, unk, pr, f, pm, re, lg, by, ah};
  endfunction

  function automatic logic [31:0] pv(input int s);
    return (32'(ne) * 32'h0001_0003) ^ (32'(s) * 32'h1100_0000) ^ 32'h0000_A5C0;
  endfunction

  task automatic push(input logic [31:0] w);
    wq[nw] = w;
    nw++;
  endtask

  task automatic add_rec(input logic [RW-1:0] r, input string tag);
    e_rec[ne] = r;
    e_end[ne] = nw;
    e_tag[ne] = tag;
    ne++;
  endtask

  // R3 / R6: vertex state with flag mask m
  task automatic add_vtx(input logic [4:0] m);
    logic [159:0] f = '0;
    int cnt = 1;
    push({3'd2, 24'h5A5A5A, m});
    for (int s = 0; s < 5; s++) if (m[s]) begin
      f[s*32 +: 32] = pv(s);
      push(pv(s));
      cnt++;
    end
    if (cnt % 2 == 1) push(32'hFFFF_FFFF);
    add_rec(mk(3'd2, 1'b0, m, f, 4'd0, 1'b0, 2'd0, 8'd0), "R3/R6 vertex");
  endtask

  // R4 / R5 / R6: index list
  task automatic add_idx(input logic [4:0] m, input logic [3:0] pm, input logic re,
      input logic [1:0] lg, input logic [7:0] ah);
    logic [159:0] f = '0;
    int cnt = 1;
    push({3'd3, 9'h1A5, ah, pm, re, lg, m});
    for (int s = 0; s < 5; s++) if (m[s]) begin
      f[s*32 +: 32] = pv(s);
      push(pv(s));
      cnt++;
    end
    if (cnt % 2 == 1) push(32'hFFFF_FFFF);
    add_rec(mk(3'd3, 1'b0, m, f, pm, re, lg, ah), "R4/R5 index");
  endtask

  // R2: state pointer
  task automatic add_ptr(input logic [7:0] ah, input logic [31:0] lo, input logic [23:0] sz);
    logic [159:0] f = '0;
    push({3'd0, 21'h0ABCD, ah});
    push(lo);
    push({8'hEE, sz});
    push(32'hFFFF_FFFF);
    f[31:0] = lo;
    f[63:32] = {8'h00, sz};
    add_rec(mk(3'd0, 1'b0, 5'b00011, f, 4'd0, 1'b0, 2'd0, ah), "R2 pointer");
  endtask

  // R7: unknown type
  task automatic add_unk(input logic [2:0] t);
    push({t, 29'h1234567});
    push(32'hDEAD_BEEF);
    add_rec(mk(t, 1'b1, 5'd0, '0, 4'd0, 1'b0, 2'd0, 8'd0), "R1/R7 unknown");
  endtask

  // R8: terminate plus words that must never be taken
  task automatic add_end();
    push({3'd6, 29'h0});
    add_rec(mk(3'd6, 1'b0, 5'd0, '0, 4'd0, 1'b0, 2'd0, 8'd0), "R8 terminate");
    push({3'd2, 24'h0, 5'b00001});
    push(32'h1111_1111);
    push(32'h2222_2222);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // input and output monitors: values seen here are pre-edge
  always @(posedge clk) begin
    if (rst) begin
      acc <= 0;
      got <= 0;
    end else begin
      if (in_valid && in_ready) acc <= acc + 1;
      if (rec_valid && rec_ready) begin
        logic [RW-1:0] a;
        a = {rec_type, rec_unknown, rec_present, rec_fields, rec_prim, rec_restart_en,
             rec_idx_log, rec_idx_bytes, rec_addr_hi};
        n_chk++;
        if (got >= ne) begin
          n_bad++;
          $display("FAIL R9 extra record %0d: got %0h expected none", got, a);
        end else begin
          if (a !== e_rec[got]) begin
            n_bad++;
            $display("FAIL %s record %0d: got %0h expected %0h", e_tag[got], got, a, e_rec[got]);
          end
          // R9 / R10: record appears exactly at its block end
          n_chk++;
          if (acc != e_end[got]) begin
            n_bad++;
            $display("FAIL R9/R10 record %0d word count: got %0d expected %0d", got, acc, e_end[got]);
          end
        end
        got <= got + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    in_valid <= run && (acc < nw) && (cyc % 5 != 3);
    in_data  <= (acc < MAXW) ? wq[acc] : 32'h0;
    rec_ready <= bp ? (cyc % 7 < 4) : 1'b1;
  end

  task automatic wait_all(input string tag);
    int g = 0;
    while (got < ne && g < 60000) begin
      @(negedge clk);
      g++;
    end
    if (got < ne) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s watchdog: got %0d records expected %0d", tag, got, ne);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!rec_valid && !done && in_ready, "R11 reset state",
        {61'd0, rec_valid, done, in_ready}, 64'd1);

    add_ptr(8'hA7, 32'h1234_5678, 24'hABCDEF);
    add_ptr(8'h00, 32'hFFFF_FFFC, 24'h000001);
    add_ptr(8'hFF, 32'h0000_0000, 24'hFFFFFF);
    for (int m = 0; m < 32; m++) add_vtx(5'(m));
    for (int m = 0; m < 32; m++)
      add_idx(5'(m), 4'(m * 3), m[1], 2'(m), 8'(m * 29 + 5));
    add_unk(3'd1);
    add_unk(3'd4);
    add_vtx(5'b10101);
    add_unk(3'd5);
    add_unk(3'd7);
    add_end();
    bp = 1'b1;
    run = 1'b1;
    wait_all("R9 phase 1");
    repeat (30) @(negedge clk);
    // R8: idle after terminate, trailing words untouched
    chk(done && !in_ready && !rec_valid, "R8 done state",
        {61'd0, done, in_ready, rec_valid}, 64'h4);
    chk(acc == e_end[ne-1], "R8 words after terminate", 64'(acc), 64'(e_end[ne-1]));
    chk(got == ne, "R9 record count", 64'(got), 64'(ne));

    run = 1'b0;
    rst = 1'b1;
    nw = 0;
    ne = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset clears done
    chk(!rec_valid && !done && in_ready, "R11 reset after done",
        {61'd0, rec_valid, done, in_ready}, 64'd1);
    add_idx(5'b11111, 4'hF, 1'b1, 2'd2, 8'h80);
    add_vtx(5'b00000);
    add_idx(5'b00000, 4'h1, 1'b0, 2'd3, 8'h01);
    add_ptr(8'h3C, 32'hCAFE_F00D, 24'h00_1000);
    add_end();
    bp = 1'b0;
    run = 1'b1;
    wait_all("R9 phase 2");
    repeat (10) @(negedge clk);
    chk(done && acc == e_end[ne-1], "R8 phase 2 end", 64'(acc), 64'(e_end[ne-1]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule